// File: doc/BRIEF.md
# USB Line State Event Detector

This block sits behind the receive pins of a USB port and turns the two raw data-line levels into bus events. Both lines first pass through a two-flop synchroniser. The registered pair is then classified as J, K, SE0 or the illegal SE1 condition. From that classified stream the block produces level flags for idle, resume and SE1. It also produces single-cycle pulses for start of packet, end of packet, bus reset and connect, and it holds a disconnect level.

Two kinds of timing qualify the events. End of packet is checked against an external bit-time strobe: the line must be SE0 on two strobes in a row and J on the strobe after them. Reset, disconnect and connect are checked against wall-clock durations. These are converted to clock cycles from a `CLK_HZ` parameter, and every change of line state restarts them.

Top module: `usb_line_event_det`

## Requirements
- R1: `line_o` carries the classified state as `{dm, dp}`: 2'b00 SE0, 2'b01 J (dp high, dm low), 2'b10 K (dp low, dm high), 2'b11 SE1. It follows an input change three clock edges later (two synchroniser flops, then the state register).
- R2: `idle_o` is high exactly while `line_o` is J, `resume_o` exactly while it is K, and `se1_o` exactly while it is SE1.
- R3: `sop_o` pulses for one cycle, in the first cycle that `line_o` shows K, and only when the previous state was J. Entering K from SE0 or SE1 gives no pulse.
- R4: `eop_o` pulses for one cycle, in the cycle after a strobe that samples J, when the two strobes before it both sampled SE0.
- R5: Any other strobe sample during the SE0, SE0, J match abandons it without a pulse. A third SE0 blocks any new match until a strobe samples a non-SE0 state.
- R6: `reset_o` pulses once when SE0 has lasted RESET_NS (2 µs by default, rounded up to whole cycles) without a break. It pulses only once however long the SE0 lasts, and never for a shorter SE0.
- R7: `disc_o` is set together with the `reset_o` pulse and stays set until a `conn_o` pulse clears it. It is set out of reset.
- R8: `conn_o` pulses once when J has lasted CONNECT_NS (2.5 µs by default) without a break.
- R9: While `disc_o` is set, `sop_o` and `eop_o` stay low.
- R10: Any change of classified state, even for one cycle, restarts the reset and connect duration counts.
- R11: Right after reset, `line_o` is SE0, `disc_o` is high and no event pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dp_i | input | 1 | Raw D+ level |
| dm_i | input | 1 | Raw D- level |
| bit_stb_i | input | 1 | One-cycle strobe per bit time |
| line_o | output | 2 | Classified line state code |
| idle_o | output | 1 | Line is J |
| resume_o | output | 1 | Line is K |
| se1_o | output | 1 | Line is in the invalid SE1 state |
| sop_o | output | 1 | Start-of-packet pulse |
| eop_o | output | 1 | End-of-packet pulse |
| reset_o | output | 1 | Long-SE0 reset pulse |
| disc_o | output | 1 | Disconnect level |
| conn_o | output | 1 | Connect pulse |

## Verification
The bench builds the block with `CLK_HZ` set to 10 MHz. The reset threshold is then 20 cycles and the connect threshold 25 cycles. This keeps both thresholds short enough that the bench can sweep SE0 and J run lengths across both sides of each boundary, cycle by cycle. Every three-bit strobe sequence over SE0, J and K is also applied, which covers every way an end-of-packet match can be abandoned or blocked.

// File: rtl/usb_lev_pkg.sv
package usb_lev_pkg;

  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_J   = 2'b01,
    LN_K   = 2'b10,
    LN_SE1 = 2'b11
  } line_e;

  // round up so a threshold is never shorter than asked
  function automatic int ns_to_cyc(input longint hz, input longint ns);
    longint c;
    c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/usb_lev_sync.sv
module usb_lev_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/usb_lev_classify.sv
module usb_lev_classify
  import usb_lev_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] raw_i,   // {dm, dp}
  output line_e      state_o,
  output line_e      prev_o,
  output logic       chg_o
);

  line_e dec, state_q, prev_q;
  logic  chg_q;

  always_comb begin
    unique case (raw_i)
      2'b00:   dec = LN_SE0;
      2'b01:   dec = LN_J;
      2'b10:   dec = LN_K;
      default: dec = LN_SE1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LN_SE0;
      prev_q  <= LN_SE0;
      chg_q   <= 1'b0;
    end else begin
      chg_q <= (dec != state_q);
      if (dec != state_q) begin
        prev_q  <= state_q;
        state_q <= dec;
      end
    end
  end

  assign state_o = state_q;
  assign prev_o  = prev_q;
  assign chg_o   = chg_q;

  assert_chg_real_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_q |-> (state_q != $past(state_q)));

  assert_prev_differs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_q |-> (prev_q != state_q));

endmodule

// File: rtl/usb_lev_timer.sv
module usb_lev_timer
  import usb_lev_pkg::*;
#(
  parameter int    CYCLES = 20,
  parameter line_e TGT    = LN_SE0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  line_e state_i,
  input  logic  chg_i,
  output logic  hit_o
);

  localparam int CNT_W = $clog2(CYCLES + 2);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(CYCLES + 1);
  localparam logic [CNT_W-1:0] THR = CNT_W'(CYCLES);

  logic [CNT_W-1:0] cnt_q, len;
  logic             hit_q;

  // len = cycles the current state has been held, including this one
  always_comb begin
    if (chg_i)             len = CNT_W'(1);
    else if (cnt_q == SAT) len = SAT;
    else                   len = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      cnt_q <= len;
      hit_q <= (state_i == TGT) && (len == THR);
    end
  end

  assign hit_o = hit_q;

  assert_hit_state_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_q |-> ($past(state_i) == TGT));

  assert_single_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_q |=> !hit_q);

endmodule

// File: rtl/usb_lev_eop.sv
module usb_lev_eop
  import usb_lev_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  line_e state_i,
  input  logic  stb_i,
  output logic  eop_o
);

  typedef enum logic [1:0] {EP_ARM, EP_Z1, EP_Z2, EP_BLK} ep_e;

  ep_e  st_q, st_d;
  logic eop_q, eop_d;

  always_comb begin
    st_d  = st_q;
    eop_d = 1'b0;
    if (stb_i) begin
      unique case (st_q)
        EP_ARM: if (state_i == LN_SE0) st_d = EP_Z1;
        EP_Z1:  st_d = (state_i == LN_SE0) ? EP_Z2 : EP_ARM;
        EP_Z2: begin
          if (state_i == LN_J) begin
            eop_d = 1'b1;
            st_d  = EP_ARM;
          end else if (state_i == LN_SE0) begin
            st_d = EP_BLK;
          end else begin
            st_d = EP_ARM;
          end
        end
        default: if (state_i != LN_SE0) st_d = EP_ARM;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= EP_ARM;
      eop_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      eop_q <= eop_d;
    end
  end

  assign eop_o = eop_q;

  assert_eop_on_j_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_q |-> ($past(state_i) == LN_J && $past(stb_i)));

  assert_eop_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_q |=> !eop_q);

endmodule

// File: rtl/usb_line_event_det.sv
module usb_line_event_det
  import usb_lev_pkg::*;
#(
  parameter int CLK_HZ      = 60_000_000,
  parameter int RESET_NS    = 2000,
  parameter int CONNECT_NS  = 2500,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dp_i,
  input  logic       dm_i,
  input  logic       bit_stb_i,
  output logic [1:0] line_o,
  output logic       idle_o,
  output logic       resume_o,
  output logic       se1_o,
  output logic       sop_o,
  output logic       eop_o,
  output logic       reset_o,
  output logic       disc_o,
  output logic       conn_o
);

  localparam int RST_CYC  = ns_to_cyc(longint'(CLK_HZ), longint'(RESET_NS));
  localparam int CONN_CYC = ns_to_cyc(longint'(CLK_HZ), longint'(CONNECT_NS));

  logic [1:0] sync_w;
  line_e      state_w, prev_w;
  logic       chg_w, rst_hit_w, conn_hit_w, eop_raw_w;
  logic       disc_q;

  usb_lev_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({dm_i, dp_i}),
    .q_o    (sync_w)
  );

  usb_lev_classify i_classify (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (sync_w),
    .state_o (state_w),
    .prev_o  (prev_w),
    .chg_o   (chg_w)
  );

  usb_lev_timer #(.CYCLES(RST_CYC), .TGT(LN_SE0)) i_rst_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state_w),
    .chg_i   (chg_w),
    .hit_o   (rst_hit_w)
  );

  usb_lev_timer #(.CYCLES(CONN_CYC), .TGT(LN_J)) i_conn_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state_w),
    .chg_i   (chg_w),
    .hit_o   (conn_hit_w)
  );

  usb_lev_eop i_eop (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state_w),
    .stb_i   (bit_stb_i),
    .eop_o   (eop_raw_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         disc_q <= 1'b1;
    else if (rst_hit_w)  disc_q <= 1'b1;
    else if (conn_hit_w) disc_q <= 1'b0;
  end

  assign line_o   = state_w;
  assign idle_o   = (state_w == LN_J);
  assign resume_o = (state_w == LN_K);
  assign se1_o    = (state_w == LN_SE1);
  assign sop_o    = chg_w && (state_w == LN_K) && (prev_w == LN_J) && !disc_q;
  assign eop_o    = eop_raw_w && !disc_q;
  assign reset_o  = rst_hit_w;
  assign conn_o   = conn_hit_w;
  assign disc_o   = disc_q;

  // edges since reset, so the latency check never looks into reset
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= '0;
    else if (age_q != 2'd3)   age_q <= age_q + 2'd1;
  end

  assert_line_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (line_o == $past({dm_i, dp_i}, 3)));

  assert_sop_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sop_o || eop_o) |-> !disc_o);

  assert_disc_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(disc_o) |-> $past(reset_o));

  assert_disc_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(disc_o) |-> $past(conn_o));

  assert_sop_from_j_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_o |-> (line_o == LN_K && $past(line_o) == LN_J));

endmodule

// File: tb/test_usb_line_event_det.sv
module test_usb_line_event_det;

  localparam logic [1:0] C_SE0 = 2'b00, C_J = 2'b01, C_K = 2'b10, C_SE1 = 2'b11;
  localparam int RST_N  = 20;  // 2 us at 10 MHz
  localparam int CONN_N = 25;  // 2.5 us at 10 MHz

  logic clk = 1'b0, rst_n = 1'b0, dp = 1'b1, dm = 1'b0, stb = 1'b0;
  logic [1:0] line;
  logic idle, resume, se1, sop, eop, rst_p, disc, conn;

  int n_sop = 0, n_eop = 0, n_rst = 0, n_conn = 0;
  int total = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  usb_line_event_det #(.CLK_HZ(10_000_000)) i_usb_line_event_det (
    .clk_i(clk), .rst_ni(rst_n), .dp_i(dp), .dm_i(dm), .bit_stb_i(stb),
    .line_o(line), .idle_o(idle), .resume_o(resume), .se1_o(se1),
    .sop_o(sop), .eop_o(eop), .reset_o(rst_p), .disc_o(disc), .conn_o(conn)
  );

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      n_sop  += int'(sop);
      n_eop  += int'(eop);
      n_rst  += int'(rst_p);
      n_conn += int'(conn);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] c);
    {dm, dp} = c;
  endtask

  task automatic hold(input logic [1:0] c, input int n);
    drive(c);
    repeat (n) @(negedge clk);
  endtask

  // one bit time: settle, strobe, report eop in the cycle after the strobe
  task automatic bit_t(input logic [1:0] c, output logic got);
    drive(c);
    repeat (3) @(negedge clk);
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    got = eop;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    logic g;
    int b0, b1, b2, b3;
    logic [1:0] sym [3];
    sym[0] = C_SE0; sym[1] = C_J; sym[2] = C_K;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11 line", int'(line), int'(C_SE0));
    chk("R11 disc", int'(disc), 1);
    chk("R11 pulses", int'(sop | eop | rst_p | conn), 0);

    hold(C_J, 40);
    chk("R8 first connect", n_conn, 1);
    chk("R7 disc cleared", int'(disc), 0);

    // R1 latency, R2 levels, R3 sop timing
    drive(C_K);
    repeat (2) @(negedge clk);
    chk("R1 before latency", int'(line), int'(C_J));
    @(negedge clk);
    chk("R1 K code", int'(line), int'(C_K));
    chk("R3 sop first K cycle", int'(sop), 1);
    chk("R2 resume", int'(resume), 1);
    chk("R2 idle off", int'(idle), 0);
    @(negedge clk);
    chk("R3 sop single", int'(sop), 0);
    hold(C_K, 3);
    hold(C_SE1, 3);
    chk("R1 SE1 code", int'(line), int'(C_SE1));
    chk("R2 se1", int'(se1), 1);
    hold(C_J, 3);
    chk("R2 idle", int'(idle), 1);
    chk("R2 se1 off", int'(se1), 0);
    hold(C_SE0, 3);
    chk("R1 SE0 code", int'(line), int'(C_SE0));
    b0 = n_sop;
    hold(C_K, 5);
    hold(C_SE1, 3);
    hold(C_K, 5);
    chk("R3 no sop from SE0/SE1", n_sop - b0, 0);
    hold(C_J, 30);

    // R4/R5 all 3-bit strobe sequences
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++) begin
          bit_t(C_K, g);
          b0 = n_eop;
          bit_t(sym[a], g);
          bit_t(sym[b], g);
          bit_t(sym[c], g);
          if (a == 0 && b == 0 && c == 1) begin
            chk("R4 eop match", n_eop - b0, 1);
            chk("R4 eop timing", int'(g), 1);
          end else begin
            chk("R5 eop abandoned", n_eop - b0, 0);
          end
        end
    bit_t(C_K, g);
    b0 = n_eop;
    bit_t(C_SE0, g); bit_t(C_SE0, g); bit_t(C_SE0, g); bit_t(C_J, g);
    chk("R5 third SE0 blocks", n_eop - b0, 0);
    bit_t(C_SE0, g); bit_t(C_SE0, g); bit_t(C_J, g);
    chk("R4 rearmed after block", n_eop - b0, 1);
    hold(C_J, 30);

    // R6/R7 reset threshold sweep
    for (int n = RST_N - 5; n <= RST_N + 5; n++) begin
      hold(C_J, 30);
      b0 = n_rst;
      hold(C_SE0, n);
      hold(C_J, 5);
      chk("R7 disc after SE0", int'(disc), int'(n >= RST_N));
      hold(C_J, 25);
      chk("R6 reset at threshold", n_rst - b0, int'(n >= RST_N));
      chk("R7 disc cleared by connect", int'(disc), 0);
    end

    b0 = n_rst; b1 = n_conn;
    hold(C_SE0, 100);
    hold(C_J, 30);
    chk("R6 reset once per SE0", n_rst - b0, 1);
    chk("R8 connect once per J", n_conn - b1, 1);

    // R10 restart of duration counts
    b0 = n_rst;
    hold(C_SE0, 15); hold(C_J, 1); hold(C_SE0, 15); hold(C_J, 30);
    chk("R10 broken SE0 no reset", n_rst - b0, 0);
    hold(C_SE0, 15); hold(C_K, 1); hold(C_SE0, RST_N); hold(C_J, 30);
    chk("R10 fresh count resets", n_rst - b0, 1);

    // R8/R7 connect threshold sweep
    for (int m = CONN_N - 3; m <= CONN_N + 3; m++) begin
      hold(C_SE0, 25);
      b1 = n_conn;
      hold(C_J, m);
      hold(C_K, 5);
      chk("R8 connect at threshold", n_conn - b1, int'(m >= CONN_N));
      chk("R7 disc held until connect", int'(disc), int'(m < CONN_N));
      hold(C_J, 30);
    end
    hold(C_SE0, 25);
    b1 = n_conn;
    hold(C_J, 20); hold(C_K, 1); hold(C_J, 20); hold(C_K, 3);
    chk("R10 broken J no connect", n_conn - b1, 0);
    hold(C_J, 30);

    // R9 suppression while disconnected
    hold(C_SE0, 25);
    hold(C_J, 5);
    b0 = n_sop; b2 = n_eop;
    bit_t(C_J, g); bit_t(C_K, g); bit_t(C_SE0, g); bit_t(C_SE0, g); bit_t(C_J, g);
    chk("R9 disc still set", int'(disc), 1);
    chk("R9 sop suppressed", n_sop - b0, 0);
    chk("R9 eop suppressed", n_eop - b2, 0);
    hold(C_J, 30);
    b3 = n_sop;
    hold(C_K, 5);
    chk("R9 sop back after connect", n_sop - b3, 1);
    hold(C_J, 10);

    done = 1'b1;
    summary();
  end

endmodule